// File: doc/BRIEF.md
# Banked Register File with Shared Status Flags

This block keeps the working registers and the status flags of a small 8-bit processor core. It has two banks, each with sixteen 8-bit registers. A bank pointer chooses which bank the two combinational read ports and the single synchronous write port reach. An interrupt handler can move to the second bank in one cycle and leave the interrupted program's registers untouched. Only the registers are banked. The zero, carry and interrupt-enable flags exist once and both banks see them.

The execution unit works out the result values and passes them in. These are an 8-bit result from logic and shift operations, and a 9-bit result from add and subtract, where bit 8 is the carry or borrow. The block derives the zero and carry flags from these inputs under a small operation code. A flag enable keeps the flags fixed during instructions that must not change them. The interrupt-enable flag has its own load port.

Top module: `regbank_flags`

## Requirements
- R1: After reset the active bank is bank A (`bank_o` = 0) and `z_o`, `c_o` and `i_o` are all 0. Register contents are not defined after reset.
- R2: While `wr_en_i` = 1, `wr_data_i` is written at the clock edge into register `wr_addr_i` of the active bank. Each read port shows, with no delay, the most recently written value of the addressed register in the active bank.
- R3: A write to one bank leaves every register of the other bank unchanged.
- R4: When `bank_set_i` = 1, `bank_sel_i` (0 = A, 1 = B) becomes the active bank from the next cycle. Reads and writes in that same cycle still use the old bank. When `bank_set_i` = 0 the bank does not change.
- R5: A read of the register being written in the same cycle returns the old value. The new value appears from the next cycle.
- R6: On an edge with `flag_en_i` = 1, Z becomes 1 exactly when the selected 8-bit result is zero. The selected result is `arith_res_i[7:0]` for codes add (1) and subtract (2), and `alu_res_i` for codes logic (0) and keep-carry (3).
- R7: On an edge with `flag_en_i` = 1, C is loaded as follows. For add (1) it takes `arith_res_i[8]`, which means the sum exceeded 255. For subtract (2) it takes `arith_res_i[8]`, which means the difference was negative. For logic (0) it is cleared. For keep-carry (3) it keeps its value.
- R8: On an edge with `flag_en_i` = 0, Z and C keep their values whatever the result inputs carry.
- R9: On an edge with `i_we_i` = 1, I takes the value of `i_val_i`. Otherwise I holds, whatever the flag enable and the bank control do.
- R10: The flags are shared by both banks. A bank switch leaves Z, C and I unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bank_set_i | input | 1 | Load the bank pointer |
| bank_sel_i | input | 1 | Bank to select, 0 = A, 1 = B |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Write register index |
| wr_data_i | input | 8 | Write data |
| rd_a_addr_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 8 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 8 | Read port B data |
| flag_en_i | input | 1 | Allow Z and C to update |
| flag_op_i | input | 2 | 0 logic, 1 add, 2 subtract, 3 keep-carry |
| alu_res_i | input | 8 | 8-bit logic/shift result |
| arith_res_i | input | 9 | Add/subtract result, bit 8 carry or borrow |
| i_we_i | input | 1 | Load interrupt-enable flag |
| i_val_i | input | 1 | New interrupt-enable value |
| bank_o | output | 1 | Active bank |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| i_o | output | 1 | Interrupt-enable flag |

## Verification
The bench builds the block with its default parameters: 8-bit data, sixteen registers and two banks. At this size it can fill every register of both banks and read all of them back after switching banks. It also reaches the exact boundaries of the flags: sums of 255 and 256, differences of 0 and -1, and a zero result with the flag enable off. A run of random cycles then mixes bank switches, writes to the register being read, and flag and interrupt-enable updates in the same cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    FOP_LOGIC = 2'd0,
    FOP_ADD   = 2'd1,
    FOP_SUB   = 2'd2,
    FOP_KEEPC = 2'd3
  } flag_op_e;
endpackage

// File: rtl/rb_bank_ctl.sv
module rb_bank_ctl #(
  parameter int BANK_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [BANK_W-1:0] sel_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bank_q <= '0;
    else if (set_i) bank_q <= sel_i;
  end

  assign bank_o = bank_q;

  // R4
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(bank_q));

  // R4
  bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> bank_q == $past(sel_i));
endmodule

// File: rtl/rb_reg_array.sv
module rb_reg_array #(
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 16,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 4,
  parameter int BANK_W    = 1
) (
  input  logic              clk_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] bank_rd_a [NUM_BANKS];
  logic [DATA_W-1:0] bank_rd_b [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic              hit;

    assign hit = we_i && (bank_i == BANK_W'(b));

    // no reset: contents are undefined until written
    always_ff @(posedge clk_i) begin
      if (hit) regs_q[waddr_i] <= wdata_i;
    end

    assign bank_rd_a[b] = regs_q[raddr_a_i];
    assign bank_rd_b[b] = regs_q[raddr_b_i];
  end

  assign rdata_a_o = bank_rd_a[bank_i];
  assign rdata_b_o = bank_rd_b[bank_i];
endmodule

// File: rtl/rb_flag_unit.sv
module rb_flag_unit
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flag_en_i,
  input  flag_op_e        op_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [DATA_W:0]   arith_res_i,
  input  logic            i_we_i,
  input  logic            i_val_i,
  output logic            z_o,
  output logic            c_o,
  output logic            i_o
);
  logic z_q, c_q, i_q;
  logic z_nxt, c_nxt;
  logic [DATA_W-1:0] z_src;

  always_comb begin
    z_src = (op_i == FOP_ADD || op_i == FOP_SUB) ? arith_res_i[DATA_W-1:0] : alu_res_i;
    z_nxt = (z_src == '0);
    unique case (op_i)
      FOP_ADD, FOP_SUB: c_nxt = arith_res_i[DATA_W];
      FOP_LOGIC:        c_nxt = 1'b0;
      default:          c_nxt = c_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
      i_q <= 1'b0;
    end else begin
      if (flag_en_i) begin
        z_q <= z_nxt;
        c_q <= c_nxt;
      end
      if (i_we_i) i_q <= i_val_i;
    end
  end

  assign z_o = z_q;
  assign c_o = c_q;
  assign i_o = i_q;

  // R8
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_en_i |=> $stable(z_q) && $stable(c_q));

  // R7
  keepc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i && op_i == FOP_KEEPC |=> $stable(c_q));

  // R7
  add_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i && op_i == FOP_ADD |=> c_q == $past(arith_res_i[DATA_W]));

  // R9
  ie_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !i_we_i |=> $stable(i_q));
endmodule

// File: rtl/regbank_flags.sv
module regbank_flags
  import regbank_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 16,
  parameter int NUM_BANKS = 2,
  localparam int ADDR_W   = $clog2(NUM_REGS),
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_set_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ADDR_W-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              flag_en_i,
  input  logic [1:0]        flag_op_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [DATA_W:0]   arith_res_i,
  input  logic              i_we_i,
  input  logic              i_val_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              z_o,
  output logic              c_o,
  output logic              i_o
);
  logic [BANK_W-1:0] bank;

  rb_bank_ctl #(.BANK_W(BANK_W)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (bank_set_i),
    .sel_i (bank_sel_i),
    .bank_o(bank)
  );

  rb_reg_array #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS),
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_regs (
    .clk_i    (clk_i),
    .bank_i   (bank),
    .we_i     (wr_en_i),
    .waddr_i  (wr_addr_i),
    .wdata_i  (wr_data_i),
    .raddr_a_i(rd_a_addr_i),
    .raddr_b_i(rd_b_addr_i),
    .rdata_a_o(rd_a_data_o),
    .rdata_b_o(rd_b_data_o)
  );

  rb_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_en_i  (flag_en_i),
    .op_i       (flag_op_e'(flag_op_i)),
    .alu_res_i  (alu_res_i),
    .arith_res_i(arith_res_i),
    .i_we_i     (i_we_i),
    .i_val_i    (i_val_i),
    .z_o        (z_o),
    .c_o        (c_o),
    .i_o        (i_o)
  );

  assign bank_o = bank;

  // R10
  switch_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_set_i && !flag_en_i && !i_we_i |=> $stable(z_o) && $stable(c_o) && $stable(i_o));
endmodule

// File: tb/sim_regbank_flags.sv
module sim_regbank_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       bank_set, bank_sel, wr_en, flag_en, i_we, i_val;
  logic [3:0] wr_addr, ra, rb;
  logic [7:0] wr_data, alu_res, rda, rdb;
  logic [8:0] arith_res;
  logic [1:0] fop;
  logic       bank_o, z_o, c_o, i_o;

  regbank_flags u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bank_set_i(bank_set), .bank_sel_i(bank_sel),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_a_addr_i(ra), .rd_a_data_o(rda),
    .rd_b_addr_i(rb), .rd_b_data_o(rdb),
    .flag_en_i(flag_en), .flag_op_i(fop),
    .alu_res_i(alu_res), .arith_res_i(arith_res),
    .i_we_i(i_we), .i_val_i(i_val),
    .bank_o(bank_o), .z_o(z_o), .c_o(c_o), .i_o(i_o)
  );

  int checks = 0, fails = 0;
  int m_rf [2][16];
  bit m_vld [2][16];
  int m_bank = 0, m_z = 0, m_c = 0, m_i = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    bank_set = 0; bank_sel = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    ra = 0; rb = 0; flag_en = 0; fop = 0; alu_res = 0; arith_res = 0;
    i_we = 0; i_val = 0;
  endtask

  // inputs already driven; compare against the model, then advance it
  task automatic cyc(string tag);
    int zs;
    #1;
    chk({tag, " R4"}, "bank", int'(bank_o), m_bank);
    chk({tag, " R6"}, "z", int'(z_o), m_z);
    chk({tag, " R7"}, "c", int'(c_o), m_c);
    chk({tag, " R9"}, "i", int'(i_o), m_i);
    if (m_vld[m_bank][ra]) chk({tag, " R2"}, "rd_a", int'(rda), m_rf[m_bank][ra]);
    if (m_vld[m_bank][rb]) chk({tag, " R5"}, "rd_b", int'(rdb), m_rf[m_bank][rb]);
    if (wr_en) begin
      m_rf[m_bank][wr_addr] = int'(wr_data);
      m_vld[m_bank][wr_addr] = 1;
    end
    if (bank_set) m_bank = int'(bank_sel);
    if (flag_en) begin
      zs = (fop == 2'd1 || fop == 2'd2) ? int'(arith_res[7:0]) : int'(alu_res);
      m_z = (zs == 0) ? 1 : 0;
      if (fop == 2'd0) m_c = 0;
      else if (fop != 2'd3) m_c = int'(arith_res[8]);
    end
    if (i_we) m_i = int'(i_val);
    @(negedge clk);
  endtask

  task automatic flag_step(string tag, logic [1:0] op, logic [7:0] a, logic [8:0] s);
    idle(); flag_en = 1; fop = op; alu_res = a; arith_res = s; cyc(tag);
  endtask

  bit done = 0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "bank", int'(bank_o), 0);
    chk("R1", "z", int'(z_o), 0);
    chk("R1", "c", int'(c_o), 0);
    chk("R1", "i", int'(i_o), 0);

    // R2 fill bank A
    for (int k = 0; k < 16; k++) begin
      idle(); wr_en = 1; wr_addr = 4'(k); wr_data = 8'(8'hA0 + k); cyc("R2");
    end
    for (int k = 0; k < 16; k++) begin
      idle(); ra = 4'(k); rb = 4'(15 - k); cyc("R2");
    end
    // R4 switch to B with a write in the same cycle (lands in A)
    idle(); bank_set = 1; bank_sel = 1; wr_en = 1; wr_addr = 3; wr_data = 8'h33; ra = 3; cyc("R4");
    // R3 fill bank B
    for (int k = 0; k < 16; k++) begin
      idle(); wr_en = 1; wr_addr = 4'(k); wr_data = 8'(8'h50 + 3 * k); cyc("R3");
    end
    idle(); bank_set = 1; bank_sel = 0; cyc("R4");
    for (int k = 0; k < 16; k++) begin
      idle(); ra = 4'(k); rb = 4'(k); cyc("R3");
    end
    // R5 write and read the same register
    idle(); wr_en = 1; wr_addr = 7; wr_data = 8'h5A; ra = 7; rb = 7; cyc("R5");
    idle(); ra = 7; rb = 7; cyc("R5");

    // R6/R7 flag boundaries
    flag_step("R7 add 255", 2'd1, 8'h00, 9'h0FF);
    flag_step("R7 add 256", 2'd1, 8'h00, 9'h100);
    flag_step("R7 sub 0", 2'd2, 8'h11, 9'h000);
    flag_step("R7 sub -1", 2'd2, 8'h00, 9'h1FF);
    flag_step("R7 keepc", 2'd3, 8'h00, 9'h000);
    flag_step("R6 logic zero", 2'd0, 8'h00, 9'h1FF);
    flag_step("R6 logic nz", 2'd0, 8'h80, 9'h000);
    flag_step("R7 add set", 2'd1, 8'h00, 9'h1FF);
    // R8 disabled update
    idle(); fop = 2'd0; alu_res = 0; arith_res = 9'h100; cyc("R8");
    idle(); fop = 2'd1; arith_res = 9'h000; cyc("R8");
    // R9 interrupt enable
    idle(); i_we = 1; i_val = 1; cyc("R9");
    idle(); flag_en = 1; fop = 2'd0; alu_res = 8'h01; cyc("R9");
    // R10 bank switch keeps flags
    idle(); bank_set = 1; bank_sel = 1; cyc("R10");
    idle(); bank_set = 1; bank_sel = 0; cyc("R10");
    idle(); cyc("R10");
    idle(); i_we = 1; i_val = 0; cyc("R9");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      idle();
      bank_set  = ($urandom_range(0, 7) == 0);
      bank_sel  = 1'($urandom);
      wr_en     = 1'($urandom);
      wr_addr   = 4'($urandom);
      wr_data   = 8'($urandom);
      ra        = ($urandom_range(0, 3) == 0) ? wr_addr : 4'($urandom);
      rb        = 4'($urandom);
      flag_en   = 1'($urandom);
      fop       = 2'($urandom);
      alu_res   = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      arith_res = ($urandom_range(0, 3) == 0) ? {1'($urandom), 8'h00} : 9'($urandom);
      i_we      = ($urandom_range(0, 5) == 0);
      i_val     = 1'($urandom);
      cyc("mix");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule